// File: doc/BRIEF.md
# Processor Program Trace Capture Unit

This block sits beside a processor and collects its program-flow trace. On every clock where capture is live it samples the 3-bit instruction-flow status and the 2-bit flush status. It also takes the address of any bus cycle that carries the trace attribute strobe. Each sample becomes an entry in a power-of-two circular buffer. Runs of plain sequential cycles fold into one entry that holds a repeat count. When a bus cycle carries the strobe after an indirect-branch status code, its entry is tagged as a branch target, so software can later rebuild the flow.

The unit has two capture modes. Both are fixed by a configuration pin, which may change only while reset is low. In pre-event mode, recording starts as soon as reset is released. The oldest entries are overwritten until an event or freeze pulse stops capture, so the buffer keeps the history that led up to the trigger. In window mode, nothing is kept until a first event pulse. Recording then runs until a second event pulse. If the buffer fills first, recording stops and an overflow flag is raised. After capture stops, a host reads the entries from oldest to newest through an indexed port that has one cycle of latency.

Top module: `trc_capture`

## Requirements
- R1: Just after reset in window mode, `done_o` is 0, `ovf_o` is 0 and `fill_o` is 0.
- R2: In pre-event mode, capture is live from reset release. Once DEPTH entries exist, each new entry replaces the oldest one and `fill_o` stays at DEPTH.
- R3: In pre-event mode, a cycle with `evt_i` or `frz_i` high is not recorded and ends capture. `done_o` reads 1 from the next cycle on, and later input activity changes neither the buffer nor `fill_o`.
- R4: In window mode, no cycle is recorded before the first `evt_i` pulse, and the pulse cycle itself is not recorded. The cycles after it are recorded up to, but not including, the next `evt_i` cycle. After that cycle `done_o` is 1.
- R5: In window mode, `frz_i` has no effect: a cycle with `frz_i` high is recorded like any other cycle.
- R6: In window mode, if a new entry is needed while DEPTH entries are already held, that entry is dropped. Capture stops, `ovf_o` and `done_o` become 1, and `fill_o` stays at DEPTH.
- R7: The entry layout is: bits [38:37] kind (0 = status, 1 = address, 2 = branch target), bits [36:34] flow status, bits [33:32] flush status, and bits [31:0] an info field.
- R8: A recorded cycle with `bus_trc_i` high gives one entry of kind 1 or 2. Its info field is `bus_addr_i`, and it holds that cycle's flow and flush status.
- R9: After a recorded cycle with flow status 3'b101, the next recorded cycle with `bus_trc_i` high gets kind 2. Later strobed cycles get kind 1 until another 3'b101 is seen. A strobed cycle that itself carries 3'b101 arms the next strobed cycle.
- R10: An idle cycle has flow status 3'b000, flush status 2'b00 and no strobe. A run of idle cycles forms status entries with zero status fields, whose info field is the run length. When a run reaches 2^RUN_W-1 cycles (15 by default), the following idle cycle opens a new entry with count 1.
- R11: A recorded cycle that is neither idle nor strobed gives a kind 0 entry with its two status fields and an info field of 0.
- R12: `fill_o` gives the number of valid entries. A read index of 0 selects the oldest entry, and `rd_data_o` shows the selected entry one cycle after `rd_idx_i` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode_win | input | 1 | 0 = pre-event capture, 1 = window capture; change only in reset |
| vf_i | input | 3 | Instruction-flow status sampled every clock |
| vfls_i | input | 2 | Flush status sampled every clock |
| bus_trc_i | input | 1 | Bus cycle carries the program-trace attribute |
| bus_addr_i | input | 32 | Bus address of the current cycle |
| evt_i | input | 1 | Trigger / window-boundary event |
| frz_i | input | 1 | Freeze indication (stops pre-event capture) |
| rd_idx_i | input | $clog2(DEPTH) | Logical read index, 0 = oldest |
| rd_data_o | output | 39 | Entry at the read index, one cycle later |
| fill_o | output | $clog2(DEPTH)+1 | Number of valid entries |
| done_o | output | 1 | Capture has stopped |
| ovf_o | output | 1 | Window capture ran out of space |

## Verification
The embedded properties rely on `mode_win` being constant between reset releases, since the full-buffer and overflow checks read it without sampling it. They also rely on the packer never asking for a new slot and an in-place count update in the same cycle. The stimulus sets the mode only while `rst_n` is low, and it issues reads only after `done_o` is high, so reading never overlaps a write. In pre-event mode, the number of cycles recorded between reset release and the first driven sample is not known exactly. The bench therefore drives at least DEPTH countable entries before it compares anything, so that entries recorded earlier have been pushed out.

// File: rtl/trc_pkg.sv
package trc_pkg;

  typedef enum logic [1:0] {
    K_STAT = 2'd0,
    K_ADDR = 2'd1,
    K_TGT  = 2'd2
  } kind_e;

  typedef struct packed {
    kind_e       kind;
    logic [2:0]  vf;
    logic [1:0]  vfls;
    logic [31:0] info;
  } trc_ent_t;

  localparam int ENT_W = $bits(trc_ent_t);

  localparam logic [2:0] VF_SEQ = 3'b000;
  localparam logic [2:0] VF_IND = 3'b101;

  typedef enum logic [1:0] {
    S_ARMED = 2'd0,
    S_RUN   = 2'd1,
    S_DONE  = 2'd2
  } cst_e;

endpackage

// File: rtl/trc_ctrl.sv
module trc_ctrl
  import trc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_win,
  input  logic evt,
  input  logic frz,
  input  logic blk,
  output logic cap_en,
  output logic done,
  output logic ovf
);

  cst_e st_q, st_d;
  logic ovf_q, ovf_d;
  logic running, stop;

  // Pre-event mode runs straight out of the armed state.
  assign running = (st_q == S_RUN) || ((st_q == S_ARMED) && !mode_win);
  assign stop    = mode_win ? evt : (evt | frz);
  assign cap_en  = running && !stop;
  assign done    = (st_q == S_DONE);
  assign ovf     = ovf_q;

  always_comb begin
    st_d  = st_q;
    ovf_d = ovf_q;
    case (st_q)
      S_ARMED: begin
        if (mode_win) begin
          if (evt) st_d = S_RUN;
        end else if (stop) begin
          st_d = S_DONE;
        end
      end
      S_RUN: begin
        if (stop) begin
          st_d = S_DONE;
        end else if (blk) begin
          st_d  = S_DONE;
          ovf_d = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_ARMED;
      ovf_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ovf_q <= ovf_d;
    end
  end

  // R3: once stopped, capture never resumes
  p_done_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R4: a closing event during a window ends capture
  p_win_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_win && (st_q == S_RUN) && evt) |=> done);

  // R6: overflow only in window mode and only with capture stopped
  p_ovf_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (done && mode_win));

endmodule

// File: rtl/trc_pack.sv
module trc_pack
  import trc_pkg::*;
#(
  parameter int RUN_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_en,
  input  logic [2:0]  vf,
  input  logic [1:0]  vfls,
  input  logic        strb,
  input  logic [31:0] addr,
  output logic        new_req,
  output logic        upd_req,
  output trc_ent_t    ent
);

  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic             idle;
  logic             run_open_q, run_open_d;
  logic [RUN_W-1:0] run_cnt_q, run_cnt_d;
  logic             pend_q, pend_d;

  assign idle = (vf == VF_SEQ) && (vfls == 2'b00) && !strb;

  always_comb begin
    new_req    = 1'b0;
    upd_req    = 1'b0;
    ent        = '0;
    run_open_d = run_open_q;
    run_cnt_d  = run_cnt_q;
    pend_d     = pend_q;
    if (cap_en) begin
      if (idle) begin
        if (run_open_q && (run_cnt_q != RUN_MAX)) begin
          upd_req   = 1'b1;
          run_cnt_d = run_cnt_q + RUN_W'(1);
        end else begin
          new_req    = 1'b1;
          run_cnt_d  = RUN_W'(1);
          run_open_d = 1'b1;
        end
        ent.kind = K_STAT;
        ent.info = 32'(run_cnt_d);
      end else begin
        new_req    = 1'b1;
        run_open_d = 1'b0;
        ent.vf     = vf;
        ent.vfls   = vfls;
        if (strb) begin
          ent.kind = pend_q ? K_TGT : K_ADDR;
          ent.info = addr;
          pend_d   = (vf == VF_IND);
        end else begin
          ent.kind = K_STAT;
          pend_d   = pend_q | (vf == VF_IND);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_open_q <= 1'b0;
      run_cnt_q  <= '0;
      pend_q     <= 1'b0;
    end else if (cap_en) begin
      run_open_q <= run_open_d;
      run_cnt_q  <= run_cnt_d;
      pend_q     <= pend_d;
    end
  end

  // R10: in-place count updates come only from idle samples
  p_upd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req |-> ((vf == VF_SEQ) && (vfls == 2'b00) && !strb));

  // R9: an unstrobed indirect-branch sample arms target tagging
  p_arm_tgt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && (vf == VF_IND) && !strb) |=> pend_q);

endmodule

// File: rtl/trc_buf.sv
module trc_buf
  import trc_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_win,
  input  logic             new_req,
  input  logic             upd_req,
  input  logic [ENT_W-1:0] ent_in,
  input  logic [AW-1:0]    rd_idx,
  output logic             blk,
  output logic [AW:0]      fill,
  output logic [ENT_W-1:0] rd_data
);

  localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST     = AW'(DEPTH - 1);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr_q, wptr_d, last_ptr, phys;
  logic             wrap_q, wrap_d;
  logic             we_new;

  assign blk      = new_req && mode_win && wrap_q;
  assign we_new   = new_req && !blk;
  assign last_ptr = wptr_q - AW'(1);
  assign phys     = wrap_q ? (wptr_q + rd_idx) : rd_idx;
  assign fill     = wrap_q ? FULL_CNT : {1'b0, wptr_q};

  always_comb begin
    wptr_d = wptr_q;
    wrap_d = wrap_q;
    if (we_new) begin
      wptr_d = wptr_q + AW'(1);
      if (wptr_q == LAST) wrap_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      wrap_q <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      wrap_q <= wrap_d;
    end
  end

  always_ff @(posedge clk) begin
    if (we_new)       mem[wptr_q]   <= ent_in;
    else if (upd_req) mem[last_ptr] <= ent_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= mem[phys];
  end

  // R10: the packer never asks for a new slot and an update together
  p_req_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(new_req && upd_req));

  // R2: once the buffer has wrapped it stays full
  p_full_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == FULL_CNT) |=> (fill == FULL_CNT));

  // R6: a window-mode entry is refused only when the buffer is full
  p_blk_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    blk |-> (fill == FULL_CNT));

endmodule

// File: rtl/trc_capture.sv
module trc_capture
  import trc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int RUN_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mode_win,
  input  logic [2:0]               vf_i,
  input  logic [1:0]               vfls_i,
  input  logic                     bus_trc_i,
  input  logic [31:0]              bus_addr_i,
  input  logic                     evt_i,
  input  logic                     frz_i,
  input  logic [$clog2(DEPTH)-1:0] rd_idx_i,
  output logic [ENT_W-1:0]         rd_data_o,
  output logic [$clog2(DEPTH):0]   fill_o,
  output logic                     done_o,
  output logic                     ovf_o
);

  logic [1:0] rs_q;
  logic       srst_n;
  logic       cap_en, blk, new_req, upd_req;
  trc_ent_t   ent;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  trc_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (srst_n),
    .mode_win (mode_win),
    .evt      (evt_i),
    .frz      (frz_i),
    .blk      (blk),
    .cap_en   (cap_en),
    .done     (done_o),
    .ovf      (ovf_o)
  );

  trc_pack #(.RUN_W(RUN_W)) u_pack (
    .clk     (clk),
    .rst_n   (srst_n),
    .cap_en  (cap_en),
    .vf      (vf_i),
    .vfls    (vfls_i),
    .strb    (bus_trc_i),
    .addr    (bus_addr_i),
    .new_req (new_req),
    .upd_req (upd_req),
    .ent     (ent)
  );

  trc_buf #(.DEPTH(DEPTH)) u_buf (
    .clk      (clk),
    .rst_n    (srst_n),
    .mode_win (mode_win),
    .new_req  (new_req),
    .upd_req  (upd_req),
    .ent_in   (ent),
    .rd_idx   (rd_idx_i),
    .blk      (blk),
    .fill     (fill_o),
    .rd_data  (rd_data_o)
  );

endmodule

// File: tb/trc_capture_tb.sv
module trc_capture_tb;

  localparam int DEPTH = 16;
  localparam int RUN_W = 4;
  localparam int RMAX  = 15;
  localparam int EW    = 39;

  logic          clk = 1'b0;
  logic          rst_n, mode_win, bus_trc_i, evt_i, frz_i;
  logic [2:0]    vf_i;
  logic [1:0]    vfls_i;
  logic [31:0]   bus_addr_i;
  logic [3:0]    rd_idx_i;
  logic [EW-1:0] rd_data_o;
  logic [4:0]    fill_o;
  logic          done_o, ovf_o;

  always #4 clk = ~clk;

  trc_capture #(.DEPTH(DEPTH), .RUN_W(RUN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_win(mode_win), .vf_i(vf_i), .vfls_i(vfls_i),
    .bus_trc_i(bus_trc_i), .bus_addr_i(bus_addr_i), .evt_i(evt_i), .frz_i(frz_i),
    .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o), .fill_o(fill_o),
    .done_o(done_o), .ovf_o(ovf_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [EW-1:0] mdl[$];
  logic [EW-1:0] exp_q[$];
  bit m_win, m_on, m_started, m_done, m_ovf, m_open, m_pend;
  int m_cnt;
  logic  rd_live = 1'b0;
  string rd_tag = "R12";

  function automatic logic [EW-1:0] mk(logic [1:0] k, logic [2:0] v,
                                       logic [1:0] f, logic [31:0] info);
    return {k, v, f, info};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  function automatic bit push_new(logic [EW-1:0] e);
    if (m_win && mdl.size() == DEPTH) begin
      m_ovf = 1; m_done = 1; m_on = 0;
      return 0;
    end
    mdl.push_back(e);
    if (mdl.size() > DEPTH) void'(mdl.pop_front());
    return 1;
  endfunction

  function automatic void model_rec(logic [2:0] v, logic [1:0] f, logic t, logic [31:0] a);
    logic [1:0] k;
    if (v == 3'b000 && f == 2'b00 && !t) begin
      if (m_open && m_cnt < RMAX) begin
        m_cnt++;
        mdl[mdl.size()-1] = mk(2'd0, 3'd0, 2'd0, 32'(m_cnt));
      end else if (push_new(mk(2'd0, 3'd0, 2'd0, 32'd1))) begin
        m_cnt = 1; m_open = 1;
      end
    end else begin
      k = t ? (m_pend ? 2'd2 : 2'd1) : 2'd0;
      if (push_new(mk(k, v, f, t ? a : 32'd0))) begin
        m_open = 0;
        m_pend = t ? (v == 3'b101) : (m_pend | (v == 3'b101));
      end
    end
  endfunction

  // Driver: applies one cycle of stimulus and pushes the expected result into the model.
  task automatic drive(logic [2:0] v, logic [1:0] f, logic t, logic [31:0] a, logic e, logic z);
    bit stop;
    @(negedge clk);
    vf_i = v; vfls_i = f; bus_trc_i = t; bus_addr_i = a; evt_i = e; frz_i = z;
    stop = m_win ? e : (e | z);
    if (m_on && !stop) model_rec(v, f, t, a);
    if (!m_done) begin
      if (m_win) begin
        if (!m_started && e) begin m_started = 1; m_on = 1; end
        else if (m_started && m_on && e) begin m_on = 0; m_done = 1; end
      end else if (e | z) begin
        m_on = 0; m_done = 1;
      end
    end
  endtask

  task automatic settle();
    drive(3'b001, 2'b00, 1'b0, 32'd0, 1'b0, 1'b0);
  endtask

  task automatic start_mode(bit win);
    @(negedge clk);
    rst_n = 1'b0; mode_win = win;
    vf_i = 3'b001; vfls_i = 2'b00; bus_trc_i = 1'b0; bus_addr_i = '0;
    evt_i = 1'b0; frz_i = 1'b0; rd_idx_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mdl.delete();
    m_win = win; m_on = !win; m_started = 0; m_done = 0; m_ovf = 0;
    m_open = 0; m_pend = 0; m_cnt = 0;
  endtask

  task automatic read_all(string tag);
    int n;
    n = mdl.size();
    exp_q = mdl;
    rd_tag = tag;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_idx_i = 4'(i);
      rd_live  = 1'b1;
    end
    @(negedge clk);
    rd_live = 1'b0;
    @(negedge clk);
    chk({tag, " leftover"}, 64'(exp_q.size()), 64'd0);
  endtask

  // Monitor: compares each read result against the next expected entry.
  always @(posedge clk) begin
    #1;
    if (rd_live) begin
      if (exp_q.size() == 0) chk({rd_tag, " extra"}, 64'd1, 64'd0);
      else chk(rd_tag, 64'(rd_data_o), 64'(exp_q.pop_front()));
    end
  end

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1 act=hung exp=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // Window capture, R1 R4 R5 R7-R12
    start_mode(1'b1);
    chk("R1 done", 64'(done_o), 64'd0);
    chk("R1 ovf", 64'(ovf_o), 64'd0);
    chk("R1 fill", 64'(fill_o), 64'd0);
    drive(3'b010, 2'b01, 1'b1, 32'h100, 1'b0, 1'b0);
    drive(3'b101, 2'b00, 1'b0, 32'h0, 1'b0, 1'b0);
    settle();
    chk("R4 pre-window fill", 64'(fill_o), 64'd0);
    drive(3'b011, 2'b00, 1'b0, 32'h0, 1'b1, 1'b0);
    drive(3'b010, 2'b01, 1'b0, 32'h0, 1'b0, 1'b0);
    drive(3'b101, 2'b00, 1'b0, 32'h0, 1'b0, 1'b0);
    repeat (3) drive(3'b000, 2'b00, 1'b0, 32'h0, 1'b0, 1'b0);
    drive(3'b000, 2'b00, 1'b1, 32'h1000_0040, 1'b0, 1'b0);
    drive(3'b000, 2'b00, 1'b1, 32'h1000_0044, 1'b0, 1'b0);
    drive(3'b101, 2'b10, 1'b1, 32'h1000_0080, 1'b0, 1'b0);
    drive(3'b000, 2'b00, 1'b1, 32'h2000_0000, 1'b0, 1'b0);
    drive(3'b011, 2'b00, 1'b0, 32'h0, 1'b0, 1'b1);
    repeat (2) drive(3'b000, 2'b00, 1'b0, 32'h0, 1'b0, 1'b0);
    drive(3'b001, 2'b00, 1'b1, 32'h3000, 1'b1, 1'b0);
    settle();
    chk("R4 done", 64'(done_o), 64'd1);
    chk("R4 ovf", 64'(ovf_o), 64'd0);
    chk("R12 fill", 64'(fill_o), 64'(mdl.size()));
    chk("R5 count", 64'(mdl.size()), 64'd9);
    read_all("R7 R8 R9 R10 R11 R12 R5 window");

    // Pre-event capture with run saturation, R2 R3 R10
    start_mode(1'b0);
    for (int i = 0; i < 16; i++) drive(3'b001, 2'(i), 1'b0, 32'h0, 1'b0, 1'b0);
    for (int i = 0; i < 20; i++) drive(3'b000, 2'b00, 1'b0, 32'h0, 1'b0, 1'b0);
    chk("R2 fill full", 64'(fill_o), 64'd16);
    drive(3'b101, 2'b00, 1'b0, 32'h0, 1'b0, 1'b0);
    drive(3'b010, 2'b00, 1'b0, 32'h0, 1'b0, 1'b0);
    drive(3'b100, 2'b00, 1'b1, 32'h0000_00A0, 1'b0, 1'b0);
    drive(3'b110, 2'b11, 1'b0, 32'h0, 1'b0, 1'b0);
    drive(3'b111, 2'b01, 1'b1, 32'hDEAD, 1'b1, 1'b0);
    settle();
    chk("R3 done evt", 64'(done_o), 64'd1);
    drive(3'b000, 2'b00, 1'b1, 32'hBEEF, 1'b0, 1'b0);
    drive(3'b101, 2'b00, 1'b0, 32'h0, 1'b1, 1'b1);
    settle();
    chk("R2 fill", 64'(fill_o), 64'd16);
    chk("R3 ovf", 64'(ovf_o), 64'd0);
    read_all("R2 R3 R9 R10 pretrace");

    // Pre-event capture stopped by freeze, R3 R8
    start_mode(1'b0);
    for (int i = 0; i < 18; i++)
      drive(3'b110, 2'b00, 1'b1, 32'h4000 + 32'(i * 4), 1'b0, 1'b0);
    drive(3'b000, 2'b00, 1'b1, 32'h9999, 1'b0, 1'b1);
    settle();
    chk("R3 done frz", 64'(done_o), 64'd1);
    drive(3'b001, 2'b00, 1'b1, 32'h7777, 1'b1, 1'b0);
    settle();
    read_all("R3 R8 freeze");

    // Window overflow, R6
    start_mode(1'b1);
    drive(3'b001, 2'b00, 1'b0, 32'h0, 1'b1, 1'b0);
    for (int i = 0; i < 20; i++)
      drive(3'b111, 2'b01, 1'b1, 32'h8000 + 32'(i), 1'b0, 1'b0);
    settle();
    chk("R6 ovf", 64'(ovf_o), 64'd1);
    chk("R6 done", 64'(done_o), 64'd1);
    chk("R6 fill", 64'(fill_o), 64'd16);
    drive(3'b001, 2'b00, 1'b1, 32'h5555, 1'b1, 1'b0);
    settle();
    read_all("R6 overflow");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule